// File: doc/BRIEF.md
# Tagged Associative Word Store

This block holds a small array of words that can be reached two ways: by coordinate address, or by content. Content access works through two full-width registers. The key register holds the pattern being looked for. The care register marks which bit positions take part in a comparison. A word matches when it agrees with the key in every position where the care register holds a 1.

The block does not give a single hit output. A search writes its outcome into one of two tag registers, with one tag bit per word. Later commands act on those tags: counting them, writing into every tagged word at once, finding the lowest tagged index, reading the tags out, or copying them to the other tag register. Each word also has an occupancy bit. A store command fills the lowest empty word without being given an address, and a release command empties a word.

Commands arrive on a valid/ready port, one per cycle. `cmd_ready` is held high at all times, so the block never applies back-pressure and a command is taken on every cycle in which `cmd_valid` is high. The result port has no ready input. A consumer must take each result in the cycle it appears.

Top module: `tagged_cam`

## Requirements
- R1: While `cmd_ready` is high, a command presented with `cmd_valid` produces `res_valid`=1 exactly one cycle later. `res_data` and `res_flag` are 0 for any command that has no result defined below, including opcode 0 (no operation). A cycle without `cmd_valid` is followed by `res_valid`=0.
- R2: Reset leaves every word at 0 and empty, both tag registers at 0, and the key and care registers at 0. Opcode 1 loads the key register from `cmd_wdata`, and opcode 2 loads the care register from `cmd_wdata`.
- R3: Opcode 3 (search) sets bit i of the tag register picked by `cmd_tsel` to 1 exactly when word i is occupied and matches the key under the care register. `res_flag`=1 when no word matched. The other tag register is left unchanged.
- R4: Opcode 4 returns in `res_data` the number of set bits in the selected tag register.
- R5: Opcode 5 (masked write) replaces the bits of word `cmd_addr` that are 1 in the care register with the matching key bits and leaves its other bits unchanged. Opcode 10 (plain write) writes `cmd_wdata` whole into word `cmd_addr`. Both mark the word occupied.
- R6: Opcode 6 (multiwrite) applies the masked write of R5 in a single cycle to every word tagged in the selected tag register and marks those words occupied. Untagged words are left unchanged.
- R7: Opcode 7 (store) writes the key into the lowest-indexed empty word, marks it occupied, and returns that index with `res_flag`=0.
- R8: Opcode 7 with every word occupied returns `res_flag`=1 and `res_data`=0, and changes no word.
- R9: Opcode 8 returns the lowest index set in the selected tag register. If no tag is set it returns `res_flag`=1 and `res_data`=0.
- R10: Opcode 9 returns word `cmd_addr`, with `res_flag`=1 when that word is empty. Opcode 15 marks word `cmd_addr` empty without changing its contents. An empty word never matches a search and can be reused by store.
- R11: On the tag register picked by `cmd_tsel`, opcode 11 sets every bit, opcode 12 clears every bit, opcode 13 returns the register in `res_data` (bit i is word i), and opcode 14 copies it into the other tag register.
- R12: With the care register set on bits 10 down to 7 and bits 3 down to 1, and the key holding 1101 in bits 10:7 and 010 in bits 3:1, a search tags exactly the occupied words that hold those values in those positions, whatever their other bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_ready | output | 1 | Always 1; a command is accepted every cycle |
| cmd_op | input | 4 | Opcode |
| cmd_tsel | input | 1 | Tag register select (0 or 1) |
| cmd_addr | input | AW | Word address for the addressed commands |
| cmd_wdata | input | WIDTH | Operand for register loads and plain write |
| res_valid | output | 1 | A result is present; pulses one cycle after the command |
| res_data | output | RW | Result value, with RW = max(WIDTH, WORDS) |
| res_flag | output | 1 | Full, no-match or empty indication |

## Verification
The hardest state to reach from the ports is one where occupancy and tags disagree. Such a state has empty slots in the middle of the array, tags set on words that are empty, and two tag registers holding different vectors. Only in that state do the lowest-index choices of store and find, the occupied-only rule of search, and the occupancy set by multiwrite lead to different outcomes.

The bench gets there in steps. It fills the array with stores until the array is full, then releases words out of order. It sets all tags and copies them across, and then re-searches into only one tag register. A behavioural model of the words, occupancy bits and tags predicts every result along this path.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_LDKEY  = 4'd1,
    OP_LDCARE = 4'd2,
    OP_SEARCH = 4'd3,
    OP_COUNT  = 4'd4,
    OP_MWRITE = 4'd5,
    OP_MULTI  = 4'd6,
    OP_STORE  = 4'd7,
    OP_FIND   = 4'd8,
    OP_READ   = 4'd9,
    OP_WRITE  = 4'd10,
    OP_TSET   = 4'd11,
    OP_TCLR   = 4'd12,
    OP_TREAD  = 4'd13,
    OP_TCOPY  = 4'd14,
    OP_FREE   = 4'd15
  } op_e;
endpackage

// File: rtl/tcam_scan.sv
// Lowest set index, any-set, and population count over a vector.
module tcam_scan #(
  parameter int N  = 8,
  parameter int AW = 3,
  parameter int CW = 4
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [AW-1:0] first,
  output logic [CW-1:0] count
);
  always_comb begin
    any   = |vec;
    first = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) first = AW'(i);
    end
    count = '0;
    for (int i = 0; i < N; i++) begin
      count = count + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/tcam_store.sv
// Word storage with occupancy bits and the per-word masked comparators.
module tcam_store #(
  parameter int WORDS = 8,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(WORDS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [WORDS-1:0]             we,
  input  logic [WIDTH-1:0]             be,
  input  logic [WIDTH-1:0]             wdata,
  input  logic [WORDS-1:0]             vclr,
  input  logic [WIDTH-1:0]             key,
  input  logic [WIDTH-1:0]             care,
  input  logic [AW-1:0]                rd_addr,
  output logic [WORDS-1:0]             occ,
  output logic [WORDS-1:0]             hit,
  output logic [WIDTH-1:0]             rd_word
);
  logic [WORDS-1:0][WIDTH-1:0] words;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [WIDTH-1:0] word_q;
    logic             occ_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
        occ_q  <= 1'b0;
      end else begin
        if (we[g]) begin
          word_q <= (word_q & ~be) | (wdata & be);
          occ_q  <= 1'b1;
        end else if (vclr[g]) begin
          occ_q  <= 1'b0;
        end
      end
    end

    assign words[g] = word_q;
    assign occ[g]   = occ_q;
    assign hit[g]   = occ_q && (((word_q ^ key) & care) == '0);
  end

  assign rd_word = words[rd_addr];
endmodule

// File: rtl/tcam_tags.sv
// Two tag bit-slice registers, one bit per word.
module tcam_tags #(
  parameter int WORDS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             ld_en,
  input  logic [WORDS-1:0] ld_val,
  input  logic             cp_en,
  output logic [WORDS-1:0] cur,
  output logic [WORDS-1:0] tag_a,
  output logic [WORDS-1:0] tag_b
);
  logic [1:0][WORDS-1:0] t_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= '0;
    end else if (ld_en) begin
      t_q[sel] <= ld_val;
    end else if (cp_en) begin
      t_q[~sel] <= t_q[sel];
    end
  end

  assign cur   = t_q[sel];
  assign tag_a = t_q[0];
  assign tag_b = t_q[1];
endmodule

// File: rtl/tagged_cam.sv
module tagged_cam #(
  parameter int WORDS = 8,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(WORDS),
  localparam int CW = $clog2(WORDS + 1),
  localparam int RW = (WIDTH > WORDS) ? WIDTH : WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [3:0]       cmd_op,
  input  logic             cmd_tsel,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [WIDTH-1:0] cmd_wdata,
  output logic             res_valid,
  output logic [RW-1:0]    res_data,
  output logic             res_flag
);
  import tcam_pkg::*;

  op_e              op;
  logic [WIDTH-1:0] key_q, care_q;
  logic [WORDS-1:0] we, vclr, addr_oh, word_valid, hit, tag_cur, tag_a, tag_b;
  logic [WORDS-1:0] tag_ld_val;
  logic             tag_ld, tag_cp;
  logic [WIDTH-1:0] be, wdata, rd_word;
  logic             free_any, tag_any;
  logic [AW-1:0]    free_first, tag_first;
  logic [CW-1:0]    free_cnt, tag_cnt;
  logic [RW-1:0]    res_d;
  logic             flag_d;

  assign op        = op_e'(cmd_op);
  assign cmd_ready = 1'b1;
  assign addr_oh   = WORDS'(1) << cmd_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      care_q <= '0;
    end else if (cmd_valid) begin
      if (op == OP_LDKEY)  key_q  <= cmd_wdata;
      if (op == OP_LDCARE) care_q <= cmd_wdata;
    end
  end

  always_comb begin
    we         = '0;
    vclr       = '0;
    be         = care_q;
    wdata      = key_q;
    tag_ld     = 1'b0;
    tag_ld_val = '0;
    tag_cp     = 1'b0;
    if (cmd_valid) begin
      unique case (op)
        OP_MWRITE: we = addr_oh;
        OP_MULTI:  we = tag_cur;
        OP_STORE: begin
          we = free_any ? (WORDS'(1) << free_first) : '0;
          be = '1;
        end
        OP_WRITE: begin
          we    = addr_oh;
          be    = '1;
          wdata = cmd_wdata;
        end
        OP_FREE:   vclr = addr_oh;
        OP_SEARCH: begin
          tag_ld     = 1'b1;
          tag_ld_val = hit;
        end
        OP_TSET: begin
          tag_ld     = 1'b1;
          tag_ld_val = '1;
        end
        OP_TCLR:   tag_ld = 1'b1;
        OP_TCOPY:  tag_cp = 1'b1;
        default: ;
      endcase
    end
  end

  tcam_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n), .we(we), .be(be), .wdata(wdata), .vclr(vclr),
    .key(key_q), .care(care_q), .rd_addr(cmd_addr), .occ(word_valid),
    .hit(hit), .rd_word(rd_word)
  );

  tcam_tags #(.WORDS(WORDS)) u_tags (
    .clk(clk), .rst_n(rst_n), .sel(cmd_tsel), .ld_en(tag_ld),
    .ld_val(tag_ld_val), .cp_en(tag_cp), .cur(tag_cur),
    .tag_a(tag_a), .tag_b(tag_b)
  );

  tcam_scan #(.N(WORDS), .AW(AW), .CW(CW)) u_free_scan (
    .vec(~word_valid), .any(free_any), .first(free_first), .count(free_cnt)
  );

  tcam_scan #(.N(WORDS), .AW(AW), .CW(CW)) u_tag_scan (
    .vec(tag_cur), .any(tag_any), .first(tag_first), .count(tag_cnt)
  );

  always_comb begin
    res_d  = '0;
    flag_d = 1'b0;
    unique case (op)
      OP_SEARCH: flag_d = ~|hit;
      OP_COUNT:  res_d  = RW'(tag_cnt);
      OP_STORE: begin
        res_d  = free_any ? RW'(free_first) : '0;
        flag_d = ~free_any;
      end
      OP_FIND: begin
        res_d  = tag_any ? RW'(tag_first) : '0;
        flag_d = ~tag_any;
      end
      OP_READ: begin
        res_d  = RW'(rd_word);
        flag_d = ~word_valid[cmd_addr];
      end
      OP_TREAD:  res_d = RW'(tag_cur);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_flag  <= 1'b0;
    end else begin
      res_valid <= cmd_valid;
      res_data  <= cmd_valid ? res_d : '0;
      res_flag  <= cmd_valid & flag_d;
    end
  end
endmodule

// File: rtl/tcam_chk.sv
module tcam_chk #(
  parameter int WORDS = 8,
  parameter int RW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [3:0]       cmd_op,
  input logic             cmd_tsel,
  input logic             res_valid,
  input logic [RW-1:0]    res_data,
  input logic             res_flag,
  input logic [WORDS-1:0] word_valid,
  input logic [WORDS-1:0] tag_a,
  input logic [WORDS-1:0] tag_b
);
  import tcam_pkg::*;

  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |=> res_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !cmd_valid |=> !res_valid); // R1
  AST_SEARCH_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SEARCH) |=> ((($past(cmd_tsel)) ? tag_b : tag_a) & ~word_valid) == '0); // R3
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_COUNT) |=> res_data <= RW'(WORDS)); // R4
  AST_STORE_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_STORE && !(&word_valid)) |=>
    (!res_flag && $countones(word_valid) == $countones($past(word_valid)) + 1)); // R7
  AST_STORE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_STORE && (&word_valid)) |=> (res_flag && $stable(word_valid))); // R8
  AST_FIND_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_FIND && ((cmd_tsel ? tag_b : tag_a) == '0)) |=> res_flag); // R9
  AST_COPY_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_TCOPY) |=> tag_a == tag_b); // R11
endmodule

bind tagged_cam tcam_chk #(.WORDS(WORDS), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_tsel(cmd_tsel), .res_valid(res_valid), .res_data(res_data),
  .res_flag(res_flag), .word_valid(word_valid), .tag_a(tag_a), .tag_b(tag_b)
);

// File: tb/sim_tagged_cam.sv
`timescale 1ns/100ps
module sim_tagged_cam;
  localparam int N = 8;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_tsel = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [2:0] cmd_addr = '0;
  logic [W-1:0] cmd_wdata = '0;
  logic cmd_ready, res_valid, res_flag;
  logic [W-1:0] res_data;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  logic [W-1:0] m_word [N];
  bit           m_vld  [N];
  bit [N-1:0]   m_tag  [2];
  logic [W-1:0] m_key = '0, m_care = '0;

  always #2.5 clk = ~clk;

  tagged_cam #(.WORDS(N), .WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_tsel(cmd_tsel), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .res_valid(res_valid), .res_data(res_data),
    .res_flag(res_flag)
  );

  task automatic expect_eq(input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Issue one command at a falling edge, check its result at the next one.
  task automatic do_cmd(input int op, input bit sel, input int addr, input logic [W-1:0] wd, input string rq);
    logic [W-1:0] ed = '0;
    bit ef = 0;
    int k = -1;
    bit [N-1:0] hv = '0;
    case (op)
      1: m_key = wd;
      2: m_care = wd;
      3: begin
        for (int i = 0; i < N; i++)
          if (m_vld[i] && ((m_word[i] ^ m_key) & m_care) == '0) hv[i] = 1;
        m_tag[sel] = hv;
        ef = (hv == '0);
      end
      4: ed = W'($countones(m_tag[sel]));
      5: begin
        m_word[addr] = (m_word[addr] & ~m_care) | (m_key & m_care);
        m_vld[addr] = 1;
      end
      6: for (int i = 0; i < N; i++)
        if (m_tag[sel][i]) begin
          m_word[i] = (m_word[i] & ~m_care) | (m_key & m_care);
          m_vld[i] = 1;
        end
      7: begin
        for (int i = 0; i < N; i++) if (!m_vld[i] && k < 0) k = i;
        if (k < 0) ef = 1;
        else begin m_word[k] = m_key; m_vld[k] = 1; ed = W'(k); end
      end
      8: begin
        for (int i = 0; i < N; i++) if (m_tag[sel][i] && k < 0) k = i;
        if (k < 0) ef = 1; else ed = W'(k);
      end
      9: begin ed = m_word[addr]; ef = !m_vld[addr]; end
      10: begin m_word[addr] = wd; m_vld[addr] = 1; end
      11: m_tag[sel] = '1;
      12: m_tag[sel] = '0;
      13: ed = W'(m_tag[sel]);
      14: m_tag[!sel] = m_tag[sel];
      15: m_vld[addr] = 0;
      default: ;
    endcase
    cmd_valid = 1; cmd_op = 4'(op); cmd_tsel = sel; cmd_addr = 3'(addr); cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 0;
    expect_eq(rq, $sformatf("op%0d res_valid", op), res_valid, 1);
    expect_eq(rq, $sformatf("op%0d res_data", op), res_data, ed);
    expect_eq(rq, $sformatf("op%0d res_flag", op), res_flag, ef);
  endtask

  task automatic idle_check();
    @(negedge clk);
    expect_eq("R1", "idle res_valid", res_valid, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_word[i] = '0; m_vld[i] = 0; end
    m_tag[0] = '0; m_tag[1] = '0;
    repeat (3) @(negedge clk);
    expect_eq("R1", "reset res_valid", res_valid, 0);
    expect_eq("R1", "cmd_ready", cmd_ready, 1);
    rst_n = 1;
    @(negedge clk);
    // R2: reset contents
    do_cmd(9, 0, 0, '0, "R2");
    do_cmd(4, 0, 0, '0, "R2");
    do_cmd(9, 0, 7, '0, "R2");
    do_cmd(8, 1, 0, '0, "R9");
    do_cmd(0, 0, 0, 16'hFFFF, "R1");
    idle_check();
    // R7: fill by store, R8: full
    for (int i = 0; i < N; i++) begin
      do_cmd(1, 0, 0, 16'h1000 + 16'(i * 16'h0111), "R2");
      do_cmd(7, 0, 0, '0, "R7");
    end
    do_cmd(7, 0, 0, '0, "R8");
    for (int i = 0; i < N; i++) do_cmd(9, 0, i, '0, "R10");
    // R3/R4/R9 exact search
    do_cmd(2, 0, 0, 16'hFFFF, "R2");
    do_cmd(1, 0, 0, 16'h1333, "R2");
    do_cmd(3, 0, 0, '0, "R3");
    do_cmd(8, 0, 0, '0, "R9");
    do_cmd(4, 0, 0, '0, "R4");
    // R12 field pattern
    do_cmd(10, 0, 0, 16'h0684, "R5");
    do_cmd(10, 0, 1, 16'hFEF5, "R5");
    do_cmd(10, 0, 2, 16'h0604, "R5");
    do_cmd(10, 0, 3, 16'h0686, "R5");
    do_cmd(10, 0, 4, 16'h0685, "R5");
    do_cmd(2, 0, 0, 16'h078E, "R12");
    do_cmd(1, 0, 0, 16'h0684, "R12");
    do_cmd(3, 1, 0, '0, "R12");
    do_cmd(13, 1, 0, '0, "R12");
    do_cmd(13, 0, 0, '0, "R3");
    do_cmd(8, 1, 0, '0, "R9");
    do_cmd(4, 1, 0, '0, "R4");
    // R6 multiwrite on tag register 1
    do_cmd(2, 0, 0, 16'h00FF, "R6");
    do_cmd(1, 0, 0, 16'h00AB, "R6");
    do_cmd(6, 1, 0, '0, "R6");
    for (int i = 0; i < 6; i++) do_cmd(9, 0, i, '0, "R6");
    // R5 masked write by address
    do_cmd(2, 0, 0, 16'hF000, "R5");
    do_cmd(1, 0, 0, 16'h5A5A, "R5");
    do_cmd(5, 0, 2, '0, "R5");
    do_cmd(9, 0, 2, '0, "R5");
    // R11 tag operations
    do_cmd(14, 1, 0, '0, "R11");
    do_cmd(13, 0, 0, '0, "R11");
    do_cmd(12, 0, 0, '0, "R11");
    do_cmd(4, 0, 0, '0, "R11");
    do_cmd(11, 1, 0, '0, "R11");
    do_cmd(4, 1, 0, '0, "R11");
    do_cmd(13, 0, 0, '0, "R11");
    // R10 release, then R7 lowest empty reuse
    do_cmd(2, 0, 0, 16'hFFFF, "R10");
    do_cmd(1, 0, 0, 16'h1555, "R10");
    do_cmd(3, 0, 0, '0, "R10");
    do_cmd(15, 0, 5, '0, "R10");
    do_cmd(3, 0, 0, '0, "R10");
    do_cmd(9, 0, 5, '0, "R10");
    do_cmd(15, 0, 6, '0, "R10");
    do_cmd(15, 0, 2, '0, "R10");
    do_cmd(1, 0, 0, 16'hBEEF, "R7");
    do_cmd(7, 0, 0, '0, "R7");
    do_cmd(9, 0, 2, '0, "R7");
    // R6: multiwrite over all-set tags refills empty words
    do_cmd(2, 0, 0, 16'h0F00, "R6");
    do_cmd(6, 1, 0, '0, "R6");
    for (int i = 0; i < N; i++) do_cmd(9, 0, i, '0, "R6");
    do_cmd(7, 0, 0, '0, "R8");
    idle_check();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule